// File: doc/BRIEF.md
# Cycle Countdown Interrupt Timer

This block counts CPU cycles down from a programmed value and raises a level interrupt-request flag when the count runs out. All control arrives as a single 5-bit control word with a one-clock commit strobe. The low four bits give the number of CPU cycles to wait. The top bit, when set, switches the timer off.

Every commit takes effect, even when the value equals the previous one. A commit with the top bit clear clears any pending request and restarts the countdown. A commit with the top bit set clears the request and stops the timer. After it fires, the timer stays stopped and the request stays raised until the next commit or reset. CPU cycles are marked by an enable input that is high for one clock per cycle.

Top module: `cycle_irq_timer`

## Requirements
- R1: After synchronous reset, `irqPending` is 0 and the timer is stopped: CPU-cycle ticks alone never raise `irqPending`.
- R2: A commit with `ctrlValue[4]`=1 makes `irqPending` 0 from the next clock edge and stops the timer, so later ticks leave `irqPending` at 0.
- R3: A commit with `ctrlValue[4]`=0 and `ctrlValue[3:0]`=N (1..15) clears `irqPending`. `irqPending` then stays 0 through the first N-1 ticks after the commit and becomes 1 at the clock edge that takes the Nth tick.
- R4: A commit with `ctrlValue[4]`=0 and `ctrlValue[3:0]`=0 behaves as N=1, so the first tick raises `irqPending`.
- R5: Once raised, `irqPending` stays 1 through any number of further ticks, until the next commit or reset. The timer does not restart by itself.
- R6: A commit of the same value as the previous commit re-arms the timer and clears a pending request. The request then rises again after the programmed count.
- R7: When a commit and a tick occur in the same clock, the commit takes effect and that tick is not counted.
- R8: Clock cycles with `cpuTick`=0 do not advance the countdown.
- R9: `irqPending` is a register output. It changes only at a clock edge, one edge after the commit or tick that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuTick | input | 1 | One-clock marker of a CPU cycle |
| ctrlValue | input | 5 | Control word: bit 4 stops the timer, bits [3:0] are the count |
| ctrlCommit | input | 1 | Strobe that commits `ctrlValue` |
| irqPending | output | 1 | Level interrupt request |

## Verification
A commit and a CPU-cycle tick can land in the same clock. The commit must win, and the tick must be lost rather than counted against the new count. The bench provokes this directly by committing a count of 2 together with a tick, and then checking that the request stays low after one more tick and rises only after a second. The random phase drives commits and ticks together often, and a cycle-level model that applies the commit-first rule judges every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Strobes from control to datapath; at most one is active per clock
  typedef struct packed {
    logic arm;     // load count, enable, clear pending
    logic disarm;  // stop, clear count and pending
    logic step;    // count one CPU cycle
  } timer_strobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          stopBit,
  input  logic          cpuTick,
  input  logic          timerOn,
  output timer_strobe_t strobes
);
  always_comb begin
    strobes.arm    = commit && !stopBit;
    strobes.disarm = commit && stopBit;
    // R7: a commit in the same clock swallows the tick
    strobes.step   = cpuTick && !commit && timerOn;
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.arm, strobes.disarm, strobes.step}));

  // R1
  no_step_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !timerOn |-> !strobes.step);
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  timer_strobe_t    strobes,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             timerOn,
  output logic             irqPending
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] loadCnt;

  always_comb begin
    nextCnt = (cntQ != ZERO) ? cntQ - ONE : ZERO;
    // R4: a zero count waits one cycle
    loadCnt = (reloadVal == ZERO) ? ONE : reloadVal;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timerOn    <= 1'b0;
      cntQ       <= ZERO;
      irqPending <= 1'b0;
    end else if (strobes.arm) begin
      timerOn    <= 1'b1;
      cntQ       <= loadCnt;
      irqPending <= 1'b0;
    end else if (strobes.disarm) begin
      timerOn    <= 1'b0;
      cntQ       <= ZERO;
      irqPending <= 1'b0;
    end else if (strobes.step) begin
      cntQ <= nextCnt;
      if (nextCnt == ZERO) begin
        irqPending <= 1'b1;
        timerOn    <= 1'b0;
      end
    end
  end

  // R6
  commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.arm || strobes.disarm) |=> !irqPending);

  // R3
  arm_loads_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.arm |=> (timerOn && cntQ != ZERO));

  // R2
  disarm_stops_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.disarm |=> (!timerOn && cntQ == ZERO));

  // R9
  rise_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irqPending) |-> $past(strobes.step));

  // R5
  pending_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (irqPending && !strobes.arm && !strobes.disarm) |=> irqPending);

  // R8
  no_count_up_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.arm |=> cntQ <= $past(cntQ));
endmodule

// File: rtl/cycle_irq_timer.sv
module cycle_irq_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cpuTick,
  input  logic [CNT_W:0] ctrlValue,
  input  logic           ctrlCommit,
  output logic           irqPending
);
  localparam int STOP_BIT = CNT_W;

  timer_strobe_t strobes;
  logic          timerOn;

  timer_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .commit  (ctrlCommit),
    .stopBit (ctrlValue[STOP_BIT]),
    .cpuTick (cpuTick),
    .timerOn (timerOn),
    .strobes (strobes)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .reloadVal  (ctrlValue[CNT_W-1:0]),
    .timerOn    (timerOn),
    .irqPending (irqPending)
  );
endmodule

// File: tb/test_cycle_irq_timer.sv
module test_cycle_irq_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpuTick;
  logic [4:0] ctrlValue;
  logic       ctrlCommit;
  logic       irqPending;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  bit mOn;
  int mCnt;
  bit mPend;

  always #5 clk = ~clk;

  cycle_irq_timer i_cycle_irq_timer (
    .clk(clk), .rst(rst), .cpuTick(cpuTick), .ctrlValue(ctrlValue),
    .ctrlCommit(ctrlCommit), .irqPending(irqPending)
  );

  function automatic int loadOf(logic [4:0] v);
    return (v[3:0] == 4'd0) ? 1 : int'(v[3:0]);
  endfunction

  task automatic modelStep(bit r, bit t, logic [4:0] v, bit c);
    if (r) begin
      mOn = 0; mCnt = 0; mPend = 0;
    end else if (c) begin
      if (v[4]) begin mOn = 0; mCnt = 0; mPend = 0; end
      else begin mOn = 1; mCnt = loadOf(v); mPend = 0; end
    end else if (t && mOn) begin
      if (mCnt > 0) mCnt--;
      if (mCnt == 0) begin mPend = 1; mOn = 0; end
    end
  endtask

  task automatic check(string req);
    compared++;
    if (irqPending !== mPend) begin
      mismatched++;
      $display("FAIL %s: irqPending actual=%0b expected=%0b at cycle %0d",
               req, irqPending, mPend, cycles);
    end
  endtask

  // drive on falling edge, step model at rising edge, sample on next falling edge
  task automatic cyc(bit r, bit t, logic [4:0] v, bit c, string req);
    rst = r; cpuTick = t; ctrlValue = v; ctrlCommit = c;
    @(posedge clk);
    modelStep(r, t, v, c);
    cycles++;
    @(negedge clk);
    check(req);
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) cyc(0, 1, 5'd0, 0, req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    rst = 1; cpuTick = 0; ctrlValue = 0; ctrlCommit = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc(1, 1, 5'd0, 0, "R1");
    ticks(5, "R1");
    // R3: count 3
    cyc(0, 0, 5'd3, 1, "R3");
    ticks(2, "R3");
    ticks(1, "R3");
    ticks(4, "R5");
    // R2: stop bit
    cyc(0, 0, 5'h13, 1, "R2");
    ticks(4, "R2");
    // R4: zero count
    cyc(0, 0, 5'd0, 1, "R4");
    ticks(1, "R4");
    // R6: same-value rewrite
    cyc(0, 0, 5'd1, 1, "R6");
    ticks(1, "R6");
    cyc(0, 0, 5'd1, 1, "R6");
    ticks(1, "R6");
    // R7: commit with tick in same clock
    cyc(0, 1, 5'd2, 1, "R7");
    ticks(1, "R7");
    ticks(1, "R7");
    // R8: idle clocks
    cyc(0, 0, 5'd4, 1, "R8");
    for (int i = 0; i < 10; i++) cyc(0, 0, 5'd0, 0, "R8");
    ticks(4, "R8");
    // R3 boundary: count 15
    cyc(0, 0, 5'd15, 1, "R3");
    ticks(15, "R3");
    // R9 / R1: reset mid-count
    cyc(0, 0, 5'd5, 1, "R9");
    ticks(2, "R9");
    cyc(1, 1, 5'd0, 0, "R1");
    ticks(8, "R1");
    // random phase
    seed = $urandom(32'h5eed);
    for (int i = 0; i < 4000; i++) begin
      bit t, c;
      logic [4:0] v;
      t = ($urandom % 3) != 0;
      c = ($urandom % 9) == 0;
      v = 5'($urandom);
      if (($urandom % 4) != 0) v[4] = 1'b0;
      cyc(0, t, v, c, (c && t) ? "R7" : "R3");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule